// File: doc/BRIEF.md
# Half-Duplex Three-Wire Serial Master

This block drives a slow serial peripheral of the clock-calendar kind over three wires: a chip enable, a serial clock and one shared data line. Each transfer moves a run of 8-bit words in one direction only. Bits go least significant first. A dedicated direction output tells the external bidirectional buffer whether the master is driving the data line or listening to it. The chip enable is active high. Guard intervals surround its assertion, so that the peripheral sees a clean, quiet bus before any clock edge arrives.

A transfer starts with a single-cycle command that carries a direction code and a byte count. Write bytes enter through a valid/ready stream. Read bytes leave through a second valid/ready stream. The serial clock idles low. Each bit is placed on the line while the clock is low, and it is captured at the falling edge that ends the high phase. The clock does not advance while the master waits for a write byte or for the consumer to take the last read byte. Both guard lengths and the half-period of the serial clock are parameters counted in system clock cycles.

Top module: `tw_serial_master`

## Requirements
- R1: While `ser_ce` is low, `ser_clk`, `ser_wen_n` and `sio_out` are all low. After reset and between transfers, all four bus outputs are low and `busy` is low.
- R2: After a command is accepted, all bus outputs stay low for exactly GUARD_CYCLES cycles and then `ser_ce` rises. At least GUARD_CYCLES further cycles pass before the first rising edge of `ser_clk`.
- R3: Every high phase of `ser_clk` lasts exactly HALF_CYCLES cycles. Every low phase inside a transfer lasts at least HALF_CYCLES cycles.
- R4: In a write, each byte appears on `sio_out` least significant bit first. A bit changes only while `ser_clk` is low and holds steady through the high phase.
- R5: In a read, the value of `sio_in` just before each falling edge of `ser_clk` is captured. The first captured bit becomes bit 0 of the byte. A finished byte is offered on `rd_data` with `rd_valid`, and both are held unchanged until `rd_ready` accepts them.
- R6: `ser_wen_n` is low for a write (`cmd_dir` = 2'b01) and high for a read (`cmd_dir` = 2'b10). It takes its value when `ser_ce` rises, before any clock edge, and stays constant while `ser_ce` is high.
- R7: During a read transfer, `sio_out` stays low.
- R8: A command moves `cmd_len` + 1 bytes, with exactly eight `ser_clk` pulses per byte.
- R9: `done` is high for one cycle at the end of a transfer, in the cycle where `ser_ce` has just dropped. `busy` is high from the cycle after acceptance through that cycle.
- R10: A command with `cmd_dir` of 2'b00 or 2'b11 is rejected. `err` pulses for one cycle in the following cycle, `busy` stays low and the bus stays quiet.
- R11: A command presented while `busy` is high is ignored.
- R12: `wr_ready` is high only while the master is waiting for the next write byte. While it waits, `ser_clk` stays low and `ser_ce` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_dir | input | 2 | 2'b01 write, 2'b10 read, other values rejected |
| cmd_len | input | LEN_W | Number of bytes minus one |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle pulse for a rejected command |
| wr_data | input | 8 | Write byte |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Master takes the write byte this cycle |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Consumer takes the read byte |
| ser_ce | output | 1 | Active-high chip enable |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_wen_n | output | 1 | Direction to the buffer: low drives, high listens |
| sio_out | output | 1 | Data toward the peripheral |
| sio_in | input | 1 | Data from the peripheral |

## Verification
The assertions take for granted that the peripheral changes `sio_in` only in response to the falling clock edge, and that the write stream, once valid, holds its byte until `wr_ready` takes it. They also take for granted that `rd_ready` is a plain level that does not depend on `rd_data`. The bench model of the peripheral updates its data bit half a system cycle after it sees the serial clock fall. Every stream input is driven on the inactive clock edge and held until the handshake completes, so the stimulus stays inside these assumptions.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_POST,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_END
  } tw_state_e;

  localparam logic [1:0] DIR_WR = 2'b01;
  localparam logic [1:0] DIR_RD = 2'b10;
  localparam int WORD_BITS = 8;

  function automatic logic dir_legal(input logic [1:0] d);
    return (d == DIR_WR) || (d == DIR_RD);
  endfunction

  // one serial bit enters at the top, earlier bits move toward bit 0
  function automatic logic [WORD_BITS-1:0] lsb_shift_in(input logic [WORD_BITS-1:0] cur,
                                                        input logic b);
    return {b, cur[WORD_BITS-1:1]};
  endfunction

  function automatic int tc_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/tw_phase_timer.sv
module tw_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] term,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= term;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/tw_lsb_shifter.sv
module tw_lsb_shifter
  import tw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] din,
  input  logic                 shift,
  input  logic                 sin,
  output logic [WORD_BITS-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (load)   q <= din;
    else if (shift)  q <= lsb_shift_in(q, sin);
  end
endmodule

// File: rtl/tw_serial_master.sv
module tw_serial_master
  import tw_pkg::*;
#(
  parameter int GUARD_CYCLES = 400,
  parameter int HALF_CYCLES  = 100,
  parameter int LEN_W        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_dir,
  input  logic [LEN_W-1:0]     cmd_len,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  output logic [WORD_BITS-1:0] rd_data,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic                 ser_ce,
  output logic                 ser_clk,
  output logic                 ser_wen_n,
  output logic                 sio_out,
  input  logic                 sio_in
);
  localparam int TMR_W = tc_width(GUARD_CYCLES, HALF_CYCLES);
  localparam int BIT_W = $clog2(WORD_BITS);
  localparam logic [TMR_W-1:0] GUARD_TC = TMR_W'(GUARD_CYCLES - 1);
  localparam logic [TMR_W-1:0] HALF_TC  = TMR_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_BITS - 1);

  tw_state_e state, state_d;
  logic                 wr_mode;
  logic [LEN_W-1:0]     bytes_left;
  logic [BIT_W-1:0]     bit_idx;
  logic                 err_q;
  logic                 rd_valid_q;
  logic [WORD_BITS-1:0] rd_data_q;

  logic                 tmr_load;
  logic [TMR_W-1:0]     tmr_term;
  logic                 tmr_done;
  logic                 sh_load;
  logic                 sh_shift;
  logic [WORD_BITS-1:0] sh_q;

  // named events, also used by the checker
  logic cmd_accept, cmd_reject, slot_ok, bit_fall, byte_end, last_byte, rd_take;

  assign cmd_accept = (state == ST_IDLE) && cmd_valid && dir_legal(cmd_dir);
  assign cmd_reject = (state == ST_IDLE) && cmd_valid && !dir_legal(cmd_dir);
  assign slot_ok    = wr_mode ? wr_valid : !rd_valid_q;
  assign bit_fall   = (state == ST_HIGH) && tmr_done;
  assign byte_end   = bit_fall && (bit_idx == LAST_BIT);
  assign last_byte  = (bytes_left == '0);
  assign rd_take    = rd_valid_q && rd_ready;

  tw_phase_timer #(.W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .term    (tmr_term),
    .expired (tmr_done)
  );

  tw_lsb_shifter u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .din   (wr_data),
    .shift (sh_shift),
    .sin   (sio_in),
    .q     (sh_q)
  );

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    tmr_term = HALF_TC;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    case (state)
      ST_IDLE: if (cmd_accept) begin
        state_d  = ST_PRE;
        tmr_load = 1'b1;
        tmr_term = GUARD_TC;
      end
      ST_PRE: if (tmr_done) begin
        state_d  = ST_POST;
        tmr_load = 1'b1;
        tmr_term = GUARD_TC;
      end
      ST_POST: if (tmr_done) state_d = ST_FETCH;
      ST_FETCH: if (slot_ok) begin
        state_d  = ST_LOW;
        tmr_load = 1'b1;
        sh_load  = wr_mode;
      end
      ST_LOW: if (tmr_done) begin
        state_d  = ST_HIGH;
        tmr_load = 1'b1;
      end
      ST_HIGH: if (tmr_done) begin
        sh_shift = 1'b1;
        if (bit_idx == LAST_BIT) begin
          state_d = last_byte ? ST_END : ST_FETCH;
        end else begin
          state_d  = ST_LOW;
          tmr_load = 1'b1;
        end
      end
      ST_END:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      wr_mode    <= 1'b0;
      bytes_left <= '0;
      bit_idx    <= '0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state <= state_d;
      err_q <= cmd_reject;
      if (cmd_accept) begin
        wr_mode    <= (cmd_dir == DIR_WR);
        bytes_left <= cmd_len;
      end else if (byte_end && !last_byte) begin
        bytes_left <= bytes_left - 1'b1;
      end
      if (state == ST_FETCH) bit_idx <= '0;
      else if (bit_fall)     bit_idx <= bit_idx + 1'b1;
      if (byte_end && !wr_mode) begin
        rd_valid_q <= 1'b1;
        rd_data_q  <= lsb_shift_in(sh_q, sio_in);
      end else if (rd_take) begin
        rd_valid_q <= 1'b0;
      end
    end
  end

  assign ser_ce    = (state == ST_POST) || (state == ST_FETCH) ||
                     (state == ST_LOW)  || (state == ST_HIGH);
  assign ser_clk   = (state == ST_HIGH);
  assign ser_wen_n = ser_ce && !wr_mode;
  assign sio_out   = wr_mode && ((state == ST_LOW) || (state == ST_HIGH)) && sh_q[0];
  assign wr_ready  = (state == ST_FETCH) && wr_mode;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_END);
  assign err       = err_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;
endmodule

// File: rtl/tw_serial_master_chk.sv
module tw_serial_master_chk #(
  parameter int GUARD_CYCLES = 400,
  parameter int HALF_CYCLES  = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       wr_ready,
  input logic [7:0] rd_data,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       ser_ce,
  input logic       ser_clk,
  input logic       ser_wen_n,
  input logic       sio_out,
  input logic       byte_end
);
  logic        clk_q;
  logic [15:0] pre_cnt, ce_cnt, hi_cnt, lo_cnt;
  logic [2:0]  fall_cnt;
  logic        sck_rise, sck_fall;

  assign sck_rise = ser_clk && !clk_q;
  assign sck_fall = !ser_clk && clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q    <= 1'b0;
      pre_cnt  <= '0;
      ce_cnt   <= '0;
      hi_cnt   <= '0;
      lo_cnt   <= '0;
      fall_cnt <= '0;
    end else begin
      clk_q <= ser_clk;
      if (!busy)                        pre_cnt <= '0;
      else if (!ser_ce && pre_cnt != '1) pre_cnt <= pre_cnt + 1'b1;
      if (!ser_ce)                      ce_cnt <= '0;
      else if (ce_cnt != '1)            ce_cnt <= ce_cnt + 1'b1;
      if (!ser_clk)                     hi_cnt <= '0;
      else if (hi_cnt != '1)            hi_cnt <= hi_cnt + 1'b1;
      if (ser_clk || !ser_ce)           lo_cnt <= '0;
      else if (lo_cnt != '1)            lo_cnt <= lo_cnt + 1'b1;
      if (sck_fall)                     fall_cnt <= fall_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_ce |-> (!ser_clk && !ser_wen_n && !sio_out)); // R1
  AST_PRE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_ce) |-> (pre_cnt == 16'(GUARD_CYCLES))); // R2
  AST_POST_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> (ce_cnt >= 16'(GUARD_CYCLES + HALF_CYCLES))); // R2
  AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |-> (hi_cnt == 16'(HALF_CYCLES))); // R3
  AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |-> (lo_cnt >= 16'(HALF_CYCLES))); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(sio_out)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5
  AST_DIR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ce && $past(ser_ce)) |-> $stable(ser_wen_n)); // R6
  AST_READ_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_wen_n |-> !sio_out); // R7
  AST_EIGHT_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |-> (fall_cnt == 3'd7)); // R8
  AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_ce && $past(ser_ce) && busy)); // R9
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !ser_ce)); // R10
  AST_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!ser_clk && ser_ce)); // R12
endmodule

bind tw_serial_master tw_serial_master_chk #(
  .GUARD_CYCLES (GUARD_CYCLES),
  .HALF_CYCLES  (HALF_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .wr_ready  (wr_ready),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .ser_ce    (ser_ce),
  .ser_clk   (ser_clk),
  .ser_wen_n (ser_wen_n),
  .sio_out   (sio_out),
  .byte_end  (byte_end)
);

// File: tb/tb_tw_serial_master.sv
module tb_tw_serial_master;
  localparam int G  = 6;
  localparam int H  = 3;
  localparam int LW = 8;
  localparam logic [1:0] WR = 2'b01;
  localparam logic [1:0] RD = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_dir = 2'b00;
  logic [LW-1:0] cmd_len = '0;
  logic busy, done, err, wr_ready, rd_valid;
  logic [7:0] wr_data = 8'h00;
  logic wr_valid = 1'b0;
  logic [7:0] rd_data;
  logic rd_ready = 1'b1;
  logic ser_ce, ser_clk, ser_wen_n, sio_out;
  logic sio_in = 1'b0;

  always #4 clk = ~clk;

  tw_serial_master #(.GUARD_CYCLES(G), .HALF_CYCLES(H), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_dir(cmd_dir),
    .cmd_len(cmd_len), .busy(busy), .done(done), .err(err),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .ser_ce(ser_ce), .ser_clk(ser_clk), .ser_wen_n(ser_wen_n),
    .sio_out(sio_out), .sio_in(sio_in)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // peripheral model and bus monitor, sampled on the inactive edge
  int pre_cnt, post_cnt, rises, falls, dones, bad_high, rd_drive, hi_run;
  int cap_bits, cap_cnt;
  bit ce_seen, sck_seen, prev_sck;
  logic wen_at_rise;
  logic [7:0] cap_sh;
  logic [7:0] cap [8];
  logic [7:0] rd_src [8];

  task automatic mon_clear();
    pre_cnt = 0; post_cnt = 0; rises = 0; falls = 0; dones = 0;
    bad_high = 0; rd_drive = 0; hi_run = 0; cap_bits = 0; cap_cnt = 0;
    ce_seen = 0; sck_seen = 0; prev_sck = 0; wen_at_rise = 1'b0; cap_sh = 8'h00;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && !ser_ce && !ce_seen) pre_cnt++;
      if (ser_ce) ce_seen = 1;
      if (ser_ce && !sck_seen && !ser_clk) post_cnt++;
      if (ser_ce && ser_wen_n && sio_out) rd_drive++;
      if (done) dones++;
      if (ser_clk && !prev_sck) begin
        rises++;
        sck_seen = 1;
        wen_at_rise = ser_wen_n;
        if (!ser_wen_n) begin
          cap_sh = {sio_out, cap_sh[7:1]};
          cap_bits++;
          if (cap_bits == 8) begin
            if (cap_cnt < 8) cap[cap_cnt] = cap_sh;
            cap_cnt++;
            cap_bits = 0;
          end
        end
      end
      if (ser_clk) hi_run++;
      if (!ser_clk && prev_sck) begin
        falls++;
        if (hi_run != H) bad_high++;
        hi_run = 0;
      end
      sio_in <= ser_ce ? rd_src[(falls / 8) % 8][falls % 8] : 1'b0;
      prev_sck = ser_clk;
    end
  end

  task automatic run_xfer(input logic [1:0] dir, input int n, input logic [7:0] seed,
                          input int stall, input int hold, input bit poke);
    logic [7:0] wexp [8];
    int wi, ri, cyc;
    bit acc;
    mon_clear();
    for (int k = 0; k < 8; k++) begin
      wexp[k]   = seed + 8'(k * 29);
      rd_src[k] = seed ^ 8'(k * 37);
    end
    wi = 0; ri = 0; cyc = 0; acc = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = dir; cmd_len = LW'(n - 1); rd_ready = (hold == 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (cyc < 4000 && !(dones > 0 && (dir == WR || ri == n))) begin
      if (acc) wi++;
      wr_valid = (dir == WR) && (wi < n) && (cyc >= stall);
      wr_data  = wexp[wi % 8];
      acc      = wr_valid && wr_ready;
      rd_ready = (cyc >= hold);
      if (rd_valid && rd_ready) begin
        chk(ri < n && rd_data == rd_src[ri % 8], "R5 read byte LSB first", rd_data, rd_src[ri % 8]);
        ri++;
      end
      if (hold > 0 && cyc == hold - 1) begin
        chk(rises == 8, "R5 clock held while read byte pending", rises, 8);
        chk(rd_valid == 1'b1, "R5 rd_valid held", rd_valid, 1);
        chk(rd_data == rd_src[0], "R5 rd_data held", rd_data, rd_src[0]);
      end
      if (stall > 0 && cyc == stall - 1) begin
        chk(ser_ce && !ser_clk && wr_ready && rises == 0, "R12 clock stalls for write byte",
            {ser_ce, ser_clk, wr_ready}, 3'b101);
      end
      if (poke && cyc == 30) begin
        cmd_valid = 1'b1; cmd_dir = RD; cmd_len = LW'(3);
      end else begin
        cmd_valid = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    wr_valid = 1'b0; rd_ready = 1'b1; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(dones == 1, "R9 one done pulse", dones, 1);
    chk(pre_cnt == G, "R2 quiet cycles before enable", pre_cnt, G);
    chk(post_cnt >= G + H, "R2 enable-to-clock guard", post_cnt, G + H);
    chk(bad_high == 0, "R3 high phase width", bad_high, 0);
    chk(rises == 8 * n && falls == 8 * n, "R8 pulse count", rises, 8 * n);
    chk(wen_at_rise == (dir == RD), "R6 direction level", wen_at_rise, (dir == RD));
    if (dir == WR) begin
      chk(cap_cnt == n, "R4 bytes captured", cap_cnt, n);
      for (int k = 0; k < n; k++)
        chk(cap[k] == wexp[k], "R4 written byte LSB first", cap[k], wexp[k]);
    end else begin
      chk(ri == n, "R5 bytes delivered", ri, n);
      chk(rd_drive == 0, "R7 data line silent in read", rd_drive, 0);
    end
    chk(!busy && !ser_ce && !ser_clk && !ser_wen_n && !sio_out, "R1 bus idle after transfer",
        {busy, ser_ce, ser_clk, ser_wen_n, sio_out}, 0);
  endtask

  task automatic bad_cmd(input logic [1:0] dir);
    mon_clear();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_dir = dir; cmd_len = LW'(2);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R10 rejected command flags err", {err, busy}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R10 err is a single pulse", err, 0);
    repeat (3 * G) @(negedge clk);
    chk(!ce_seen && rises == 0 && !busy, "R10 no bus activity", ce_seen, 0);
  endtask

  // {dir, bytes, seed}
  localparam logic [13:0] VEC [6] = '{
    {2'b01, 4'd1, 8'hA5},
    {2'b01, 4'd3, 8'h3C},
    {2'b10, 4'd1, 8'h5A},
    {2'b10, 4'd4, 8'hC3},
    {2'b01, 4'd2, 8'h01},
    {2'b10, 4'd2, 8'hFF}
  };

  bit finished = 0;

  initial begin
    mon_clear();
    for (int k = 0; k < 8; k++) rd_src[k] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !rd_valid && !wr_ready, "R1 reset status", busy, 0);
    chk(!ser_ce && !ser_clk && !ser_wen_n && !sio_out, "R1 reset bus low",
        {ser_ce, ser_clk, ser_wen_n, sio_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int v = 0; v < 6; v++)
      run_xfer(VEC[v][13:12], int'(VEC[v][11:8]), VEC[v][7:0], 0, 0, 0);
    bad_cmd(2'b00);
    bad_cmd(2'b11);
    run_xfer(WR, 1, 8'h96, 2 * G + 20, 0, 0);  // R12 write stall
    run_xfer(RD, 2, 8'h4B, 0, 90, 0);          // R5 read back-pressure
    run_xfer(WR, 2, 8'h11, 0, 0, 1);           // R11 command while busy
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule